// File: doc/BRIEF.md
# Matched Offset-Removal Filter Pair with Power Multiplier

This block takes two signed sample streams, one for line current and one for line voltage, which arrive together on a single sample strobe. Each stream passes through its own first-order digital high-pass filter, and this filter strips any DC offset from it. The two filtered samples are then multiplied. The product is the instantaneous power, and its DC component carries the real power. A later averaging stage, which is not part of this block, extracts that value.

The two filter channels come from one generated module with one coefficient. They update on the same clock edge from the same strobe, so any phase delay one of them adds is matched exactly by the other. Driving the enable input low makes the multiplier use the raw samples in place of the filtered ones. The filter states keep running while the filters are bypassed.

The filter recurrence is y_next = floor(COEF·(y + (x − xPrev)·2^8) / 2^15). Here y is a 24-bit signed state, xPrev is the previous 16-bit input, and COEF defaults to 32540. That value is a cutoff near 4.45 Hz at a 4 kHz sample rate. The filtered sample is the upper 16 bits of y.

Top module: `dc_block_power`

## Requirements
- R1: A synchronous active-high rst clears both filter states, both previous-input registers and the product register. While rst is held, powValid reads 0 and powOut reads 0.
- R2: A strobe sampled at clock edge k makes powValid go high for exactly one cycle, the cycle after edge k+1. Strobes may come on every cycle, and each one yields exactly one result. powValid is never high without a matching strobe.
- R3: When the enable input is high at the strobe, powOut is the signed 32-bit product of the two filtered samples. Each filtered sample is bits [23:8] of that channel's state after the recurrence given above.
- R4: Both channels use the same recurrence and coefficient and update on the same edge. Equal current and voltage input histories therefore give equal filtered samples, so powOut is a square and is never negative.
- R5: After a long run of a constant input (3000 samples), the magnitude of each filtered sample is at most 1 LSB.
- R6: When hpfEn is 0 at the strobe, powOut for that sample equals the raw current input times the raw voltage input, as a signed product.
- R7: The filter state saturates at 2^23−1 or −2^23 and never wraps. A full-scale step from −32768 to 32767 after a settled negative input gives a filtered sample of 32767.
- R8: The filter states and previous-input registers update on every strobe, whatever the state of hpfEn. When filtering is enabled again, the result continues the recurrence over every sample, including the bypassed ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Sample strobe shared by both channels |
| curIn | input | 16 | Signed current sample |
| voltIn | input | 16 | Signed voltage sample |
| hpfEn | input | 1 | 1: filtered samples feed the multiplier; 0: raw samples feed it |
| powValid | output | 1 | Product valid, one pulse per strobe |
| powOut | output | 32 | Signed instantaneous power |

## Verification
On every cycle, the assertions check the fixed two-cycle link between strobe and result, the absence of results without a strobe, the bypass product against the raw inputs, and the reset state. The bench's scenarios, scored against a model of the recurrence, are the only way to show the slow behaviours: matched channels giving non-negative squares, decay to within one LSB under a constant input, saturation on a full-scale step, and continuity of the filter state across a bypass interval.

// File: rtl/dc_block_power_pkg.sv
package dc_block_power_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic filtLoad;  // advance both filter channels
    logic prodLoad;  // register the product
    logic rawSel;    // multiplier takes raw samples
  } ctrl_strobes_t;

endpackage

// File: rtl/hpf_channel.sv
module hpf_channel #(
  parameter int IN_W = 16,
  parameter int ST_W = 24,
  parameter int FRAC = 15,
  parameter int COEF = 32540
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic signed [IN_W-1:0] xIn,
  output logic signed [IN_W-1:0] yOut,
  output logic signed [IN_W-1:0] xLast
);
  localparam int GUARD  = ST_W - IN_W;
  localparam int SUM_W  = ST_W + 2;
  localparam int PROD_W = SUM_W + FRAC + 1;
  localparam logic signed [FRAC:0]     COEF_S = (FRAC+1)'(COEF);
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((longint'(1) <<< (ST_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

  logic signed [ST_W-1:0]   state, stateNext;
  logic signed [IN_W-1:0]   xPrev;
  logic signed [IN_W:0]     delta;
  logic signed [SUM_W-1:0]  sum;
  logic signed [PROD_W-1:0] scaled;

  always_comb begin
    delta  = (IN_W+1)'(xIn) - (IN_W+1)'(xPrev);
    sum    = SUM_W'(state) + (SUM_W'(delta) <<< GUARD);
    scaled = (PROD_W'(sum) * PROD_W'(COEF_S)) >>> FRAC;
    if (scaled > MAXV)      stateNext = MAXV[ST_W-1:0];
    else if (scaled < MINV) stateNext = MINV[ST_W-1:0];
    else                    stateNext = scaled[ST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
      xPrev <= '0;
    end else if (load) begin
      state <= stateNext;
      xPrev <= xIn;
    end
  end

  assign yOut  = state[ST_W-1 -: IN_W];
  assign xLast = xPrev;
endmodule

// File: rtl/dc_block_power_ctrl.sv
module dc_block_power_ctrl
  import dc_block_power_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sampleValid,
  input  logic          hpfEn,
  output ctrl_strobes_t strb,
  output logic          powValid
);
  logic s1Valid, rawSelR, outValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      rawSelR  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= sampleValid;
      outValid <= s1Valid;
      if (sampleValid) rawSelR <= !hpfEn;
    end
  end

  always_comb begin
    strb.filtLoad = sampleValid;
    strb.prodLoad = s1Valid;
    strb.rawSel   = rawSelR;
  end

  assign powValid = outValid;
endmodule

// File: rtl/dc_block_power_dp.sv
module dc_block_power_dp
  import dc_block_power_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int ST_W = 24,
  parameter int FRAC = 15,
  parameter int COEF = 32540
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_strobes_t            strb,
  input  logic signed [IN_W-1:0]   curIn,
  input  logic signed [IN_W-1:0]   voltIn,
  output logic signed [2*IN_W-1:0] powOut
);
  localparam int NCH = 2;

  logic signed [IN_W-1:0] chIn   [NCH];
  logic signed [IN_W-1:0] chFilt [NCH];
  logic signed [IN_W-1:0] chRaw  [NCH];
  logic signed [IN_W-1:0] selCur, selVolt;

  assign chIn[0] = curIn;
  assign chIn[1] = voltIn;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    hpf_channel #(.IN_W(IN_W), .ST_W(ST_W), .FRAC(FRAC), .COEF(COEF)) u_hpf (
      .clk  (clk),
      .rst  (rst),
      .load (strb.filtLoad),
      .xIn  (chIn[ch]),
      .yOut (chFilt[ch]),
      .xLast(chRaw[ch])
    );
  end

  assign selCur  = strb.rawSel ? chRaw[0] : chFilt[0];
  assign selVolt = strb.rawSel ? chRaw[1] : chFilt[1];

  always_ff @(posedge clk) begin
    if (rst)                powOut <= '0;
    else if (strb.prodLoad) powOut <= (2*IN_W)'(selCur) * (2*IN_W)'(selVolt);
  end
endmodule

// File: rtl/dc_block_power.sv
module dc_block_power
  import dc_block_power_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int ST_W = 24,
  parameter int FRAC = 15,
  parameter int COEF = 32540
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleValid,
  input  logic signed [IN_W-1:0]   curIn,
  input  logic signed [IN_W-1:0]   voltIn,
  input  logic                     hpfEn,
  output logic                     powValid,
  output logic signed [2*IN_W-1:0] powOut
);
  ctrl_strobes_t strb;

  dc_block_power_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .hpfEn      (hpfEn),
    .strb       (strb),
    .powValid   (powValid)
  );

  dc_block_power_dp #(.IN_W(IN_W), .ST_W(ST_W), .FRAC(FRAC), .COEF(COEF)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .curIn (curIn),
    .voltIn(voltIn),
    .powOut(powOut)
  );
endmodule

// File: rtl/dc_block_power_chk.sv
module dc_block_power_chk #(
  parameter int IN_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sampleValid,
  input logic signed [IN_W-1:0]   curIn,
  input logic signed [IN_W-1:0]   voltIn,
  input logic                     hpfEn,
  input logic                     powValid,
  input logic signed [2*IN_W-1:0] powOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!powValid && powOut == '0));

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> ##2 powValid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> ##2 !powValid);

  // R6
  bypass_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !hpfEn) |-> ##2
      (powOut == (2*IN_W)'($past(curIn, 2)) * (2*IN_W)'($past(voltIn, 2))));
endmodule

bind dc_block_power dc_block_power_chk #(.IN_W(IN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .curIn      (curIn),
  .voltIn     (voltIn),
  .hpfEn      (hpfEn),
  .powValid   (powValid),
  .powOut     (powOut)
);

// File: tb/dc_block_power_bench.sv
module dc_block_power_bench;
  localparam longint COEF = 32540;
  localparam longint SMAX = (64'sd1 <<< 23) - 1;
  localparam longint SMIN = -(64'sd1 <<< 23);

  typedef struct {
    longint val;
    int     due;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic signed [15:0] curIn = '0, voltIn = '0;
  logic hpfEn = 1'b1;
  logic powValid;
  logic signed [31:0] powOut;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  exp_t expQ[$];
  longint yC = 0, yV = 0, xpC = 0, xpV = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dc_block_power u_dc_block_power (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .curIn(curIn),
    .voltIn(voltIn), .hpfEn(hpfEn), .powValid(powValid), .powOut(powOut)
  );

  function automatic longint stepY(longint y, longint x, longint xp);
    longint n;
    n = ((y + (x - xp) * 256) * COEF) >>> 15;
    if (n > SMAX) n = SMAX;
    if (n < SMIN) n = SMIN;
    return n;
  endfunction

  function automatic longint outOf(longint y);
    return y >>> 8;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: one strobe, model update, expected item pushed
  task automatic sendSample(longint c, longint v, bit en, string tag);
    exp_t e;
    @(negedge clk);
    curIn = 16'(c); voltIn = 16'(v); hpfEn = en; sampleValid = 1'b1;
    yC = stepY(yC, c, xpC); xpC = c;
    yV = stepY(yV, v, xpV); xpV = v;
    e.val = en ? outOf(yC) * outOf(yV) : c * v;
    e.due = cyc + 2;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (expQ.size() > 0 && expQ[0].due < cyc) begin
        check(0, "R2 missing result", 0, expQ[0].due);
        void'(expQ.pop_front());
      end
      if (powValid) begin
        if (expQ.size() == 0) begin
          check(0, "R2 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(e.due == cyc, "R2 latency", cyc, e.due);
          check(longint'(powOut) == e.val, e.tag, powOut, e.val);
          if (e.tag == "R4") check(powOut >= 0, "R4 square sign", powOut, 0);
          if (e.tag == "R5") check(powOut <= 1, "R5 decay", powOut, 1);
          if (e.tag == "R7") check(powOut == 32'sd1073676289, "R7 saturation", powOut, 1073676289);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(powValid == 1'b0, "R1 valid", powValid, 0);
    check(powOut == '0, "R1 product", powOut, 0);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R3: distinct inputs, spaced strobes
    sendSample(1200, -800, 1, "R3");  idle(2);
    sendSample(-3000, 4500, 1, "R3"); idle(1);
    sendSample(32767, -32768, 1, "R3"); idle(3);
    // R2: back-to-back strobes
    for (int i = 0; i < 6; i++) sendSample(i * 5000 - 12000, 9000 - i * 3000, 1, "R3");
    idle(3);

    // R4: equal inputs on both channels (states still differ, so resettle)
    @(negedge clk) rst = 1'b1;
    yC = 0; yV = 0; xpC = 0; xpV = 0;
    @(negedge clk) rst = 1'b0;
    idle(1);
    for (int i = 0; i < 16; i++) sendSample((i % 4) * 7000 - 9000, (i % 4) * 7000 - 9000, 1, "R4");
    idle(3);

    // R6: bypass with raw product
    sendSample(-1234, 5678, 0, "R6");
    sendSample(32767, 32767, 0, "R6");
    sendSample(-32768, 2, 0, "R6");
    // R8: state kept advancing during bypass
    sendSample(3000, 3000, 1, "R8");
    sendSample(-500, -500, 1, "R8");
    idle(3);

    // R5: constant input decays
    for (int i = 0; i < 2999; i++) sendSample(-32768, -32768, 1, "R3");
    sendSample(-32768, -32768, 1, "R5");
    // R7: full-scale step saturates
    sendSample(32767, 32767, 1, "R7");
    sendSample(32767, 32767, 1, "R3");
    idle(4);
    check(expQ.size() == 0, "R2 drained", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule